// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Window

This block turns each host read into one complete serial-flash read transaction. When the window is enabled, a request carries a byte offset and a length of one to four bytes. The engine then drives chip select low and shifts out a one-byte opcode. Next it sends a 24-bit or 32-bit address, equal to the request offset, and waits the configured number of dummy clocks. It captures the data on one, two or four lanes, releases chip select, and returns the bytes as a single little-endian word.

The opcode is not programmed. It is chosen from the class settings: plain, fast, dual-output, quad-output, each with a 3-byte or 4-byte address form. The opcode and address always go out on lane 0. Only the data phase widens. When the window is disabled, a separate register-driven engine owns the flash pins through a pass-through multiplexer. Ownership changes only while no transaction is in flight.

The host side uses two valid/ready streams. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the window is enabled and the engine is idle, so a second request waits until the whole flash cycle has finished and its response has been consumed. The response holds `rsp_valid` and `rsp_data` steady until `rsp_ready` is seen high.

Top module: `flash_map_reader`

## Requirements
- R1: After reset `flash_cs_n` is 1, `flash_sck` is 0, `rsp_valid` is 0 and `req_ready` equals `map_en`. While the window owns the pins and is idle, chip select is high and the serial clock is low.
- R2: The opcode is chosen by priority. A `cfg_width` with bit 1 set (quad) gives 6Bh. Otherwise bit 0 set (dual) gives 3Bh. Otherwise `cfg_fast` set gives 0Bh. Otherwise the opcode is 03h. When the 4-byte form applies, these become 6Ch, 3Ch, 0Ch and 13h.
- R3: The address has 4 bytes only when `cfg_byte4_en` is 1 and `cfg_addr_len` is 4. Otherwise it is `req_addr[23:0]`. The opcode and address go out MSB first on `flash_io_out[0]`, which changes while `flash_sck` is low. The flash samples it on the rising edge.
- R4: The dummy phase lasts `cfg_dummy` clocks when the read is fast, dual or quad, and 0 clocks for a plain read. One transaction makes exactly 8 + address bits + dummy + 8·bytes/lanes rising edges of `flash_sck`.
- R5: Data is sampled on rising edges of `flash_sck`, MSB first. Single mode uses `flash_io_in[1]`. Dual mode carries bits 7,6 on lanes 1,0. Quad mode carries bits 7..4 on lanes 3..0. `flash_io_oe` is 0001 during opcode and address, and 0000 during dummy and data.
- R6: Chip select goes low in the cycle after acceptance and stays low for the whole transaction. It is high again before `rsp_valid` rises.
- R7: `req_len` + 1 bytes are read from consecutive addresses. Byte i lands in `rsp_data[8i+7:8i]`, and unread upper bytes are zero.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold. A request is not accepted again in the cycle after acceptance.
- R9: With `map_en` low, `req_ready` is 0. While idle, the flash pins follow `reg_cs_n`, `reg_sck`, `reg_io_out` and `reg_io_oe`.
- R10: The configuration inputs are captured at acceptance. Changing them during a transaction has no effect on that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_en | input | 1 | Window enable; low hands pins to register engine |
| cfg_width | input | 2 | Data lane select: 00 single, 01 dual, 1x quad |
| cfg_fast | input | 1 | Fast-read class (adds dummy phase) |
| cfg_addr_len | input | 3 | Address length field in bytes |
| cfg_byte4_en | input | 1 | 4-byte addressing enable |
| cfg_dummy | input | 4 | Dummy clock count |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request accepted when high with valid |
| req_addr | input | 32 | Byte offset in the window (flash address) |
| req_len | input | 2 | Byte count minus one |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Host accepts read data |
| rsp_data | output | 32 | Little-endian read data |
| reg_cs_n | input | 1 | Register engine chip select |
| reg_sck | input | 1 | Register engine serial clock |
| reg_io_out | input | 4 | Register engine lane outputs |
| reg_io_oe | input | 4 | Register engine lane output enables |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sck | output | 1 | Flash serial clock (idle low) |
| flash_io_out | output | 4 | Flash lane outputs |
| flash_io_oe | output | 4 | Flash lane output enables |
| flash_io_in | input | 4 | Flash lane inputs |

## Verification
The bound checker watches several handshake and pin rules on every clock:
- the response holding still under back-pressure;
- no back-to-back acceptance;
- chip select falling at acceptance and high while a response waits;
- only lane 0 ever driven by the window;
- the pins following the register engine when the window is off and idle.

Other behaviour shows only in the bench scenarios, where a behavioural flash model decodes what it receives. These are the opcode and address actually shifted out, the exact number of dummy and data clocks, and the lane-to-bit mapping of returned bytes. The same holds for the little-endian packing and for configuration changes made mid-transfer being ignored.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_DUMMY,
    ST_DATA,
    ST_RESP
  } seq_state_t;

  // lane count as log2: 0 single, 1 dual, 2 quad
  function automatic logic [7:0] read_opcode(input logic [1:0] lanes_log,
                                             input logic fast,
                                             input logic addr4);
    logic [7:0] op;
    if (lanes_log == 2'd2)      op = addr4 ? 8'h6C : 8'h6B;
    else if (lanes_log == 2'd1) op = addr4 ? 8'h3C : 8'h3B;
    else if (fast)              op = addr4 ? 8'h0C : 8'h0B;
    else                        op = addr4 ? 8'h13 : 8'h03;
    return op;
  endfunction

endpackage

// File: rtl/fr_opcode_sel.sv
module fr_opcode_sel
  import flash_rd_pkg::*;
(
  input  logic [1:0] cfg_width,
  input  logic       cfg_fast,
  input  logic [2:0] cfg_addr_len,
  input  logic       cfg_byte4_en,
  input  logic [3:0] cfg_dummy,
  output logic [1:0] lanes_log,
  output logic       addr4,
  output logic [3:0] dummy_eff,
  output logic [7:0] opcode
);
  always_comb begin
    if (cfg_width[1])      lanes_log = 2'd2;
    else if (cfg_width[0]) lanes_log = 2'd1;
    else                   lanes_log = 2'd0;
    addr4     = cfg_byte4_en && (cfg_addr_len == 3'd4);
    dummy_eff = (cfg_fast || (lanes_log != 2'd0)) ? cfg_dummy : 4'd0;
    opcode    = read_opcode(lanes_log, cfg_fast, addr4);
  end
endmodule

// File: rtl/fr_sequencer.sv
module fr_sequencer
  import flash_rd_pkg::*;
#(
  parameter int BUS_BYTES = 4,
  parameter int LEN_W     = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [7:0]             opcode,
  input  logic                   addr4,
  input  logic [3:0]             dummy_eff,
  input  logic [1:0]             lanes_log,
  input  logic [31:0]            addr,
  input  logic [LEN_W-1:0]       len_m1,
  input  logic                   rsp_ready,
  output logic                   busy,
  output logic                   rsp_valid,
  output logic [BUS_BYTES*8-1:0] rsp_data,
  output logic                   cs_n,
  output logic                   sck,
  output logic [3:0]             io_out,
  output logic [3:0]             io_oe,
  input  logic [3:0]             io_in
);
  localparam int ACC_W = BUS_BYTES * 8;
  localparam int SH_W  = 40;
  localparam int CNT_W = $clog2((ACC_W > SH_W ? ACC_W : SH_W) + 1);

  seq_state_t           state;
  logic [SH_W-1:0]      shreg;
  logic [CNT_W-1:0]     cnt;
  logic [ACC_W-1:0]     acc;
  logic [1:0]           lanes_q;
  logic [3:0]           dummy_q;
  logic [LEN_W-1:0]     len_q;

  function automatic logic [CNT_W-1:0] data_cycles(input logic [LEN_W-1:0] n,
                                                   input logic [1:0] lg);
    logic [CNT_W-1:0] bits;
    bits = CNT_W'((int'(n) + 1) * 8);
    return bits >> lg;
  endfunction

  function automatic logic [ACC_W-1:0] pack_le(input logic [ACC_W-1:0] a,
                                               input logic [LEN_W-1:0] n);
    logic [ACC_W-1:0] r;
    r = '0;
    for (int i = 0; i < BUS_BYTES; i++) begin
      if (i <= int'(n)) r[8*i +: 8] = a[8*(int'(n)-i) +: 8];
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      cnt      <= '0;
      acc      <= '0;
      lanes_q  <= '0;
      dummy_q  <= '0;
      len_q    <= '0;
      cs_n     <= 1'b1;
      sck      <= 1'b0;
      rsp_data <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          shreg   <= addr4 ? {opcode, addr} : {opcode, addr[23:0], 8'h00};
          cnt     <= addr4 ? CNT_W'(40) : CNT_W'(32);
          lanes_q <= lanes_log;
          dummy_q <= dummy_eff;
          len_q   <= len_m1;
          acc     <= '0;
          cs_n    <= 1'b0;
          state   <= ST_SEND;
        end
        ST_SEND, ST_DUMMY, ST_DATA: begin
          if (!sck) begin
            sck <= 1'b1;
            if (state == ST_DATA) begin
              case (lanes_q)
                2'd1:    acc <= {acc[ACC_W-3:0], io_in[1:0]};
                2'd2:    acc <= {acc[ACC_W-5:0], io_in};
                default: acc <= {acc[ACC_W-2:0], io_in[1]};
              endcase
            end
          end else begin
            sck <= 1'b0;
            if (state == ST_SEND) shreg <= {shreg[SH_W-2:0], 1'b0};
            if (cnt == CNT_W'(1)) begin
              if (state == ST_SEND && dummy_q != 4'd0) begin
                state <= ST_DUMMY;
                cnt   <= CNT_W'(dummy_q);
              end else if (state != ST_DATA) begin
                state <= ST_DATA;
                cnt   <= data_cycles(len_q, lanes_q);
              end else begin
                state    <= ST_RESP;
                cs_n     <= 1'b1;
                rsp_data <= pack_le(acc, len_q);
              end
            end else begin
              cnt <= cnt - CNT_W'(1);
            end
          end
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign io_out    = {3'b000, shreg[SH_W-1]};
  assign io_oe     = (state == ST_SEND) ? 4'b0001 : 4'b0000;
endmodule

// File: rtl/fr_pin_mux.sv
module fr_pin_mux (
  input  logic       own,
  input  logic       eng_cs_n,
  input  logic       eng_sck,
  input  logic [3:0] eng_io_out,
  input  logic [3:0] eng_io_oe,
  input  logic       reg_cs_n,
  input  logic       reg_sck,
  input  logic [3:0] reg_io_out,
  input  logic [3:0] reg_io_oe,
  output logic       pin_cs_n,
  output logic       pin_sck,
  output logic [3:0] pin_io_out,
  output logic [3:0] pin_io_oe
);
  always_comb begin
    pin_cs_n   = own ? eng_cs_n   : reg_cs_n;
    pin_sck    = own ? eng_sck    : reg_sck;
    pin_io_out = own ? eng_io_out : reg_io_out;
    pin_io_oe  = own ? eng_io_oe  : reg_io_oe;
  end
endmodule

// File: rtl/flash_map_reader.sv
module flash_map_reader #(
  parameter int BUS_BYTES = 4,
  parameter int LEN_W     = $clog2(BUS_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   map_en,
  input  logic [1:0]             cfg_width,
  input  logic                   cfg_fast,
  input  logic [2:0]             cfg_addr_len,
  input  logic                   cfg_byte4_en,
  input  logic [3:0]             cfg_dummy,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [31:0]            req_addr,
  input  logic [LEN_W-1:0]       req_len,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [BUS_BYTES*8-1:0] rsp_data,
  input  logic                   reg_cs_n,
  input  logic                   reg_sck,
  input  logic [3:0]             reg_io_out,
  input  logic [3:0]             reg_io_oe,
  output logic                   flash_cs_n,
  output logic                   flash_sck,
  output logic [3:0]             flash_io_out,
  output logic [3:0]             flash_io_oe,
  input  logic [3:0]             flash_io_in
);
  logic [1:0] lanes_log;
  logic       addr4;
  logic [3:0] dummy_eff;
  logic [7:0] opcode;
  logic       busy;
  logic       eng_cs_n, eng_sck;
  logic [3:0] eng_io_out, eng_io_oe;

  assign req_ready = map_en && !busy;

  fr_opcode_sel u_sel (
    .cfg_width    (cfg_width),
    .cfg_fast     (cfg_fast),
    .cfg_addr_len (cfg_addr_len),
    .cfg_byte4_en (cfg_byte4_en),
    .cfg_dummy    (cfg_dummy),
    .lanes_log    (lanes_log),
    .addr4        (addr4),
    .dummy_eff    (dummy_eff),
    .opcode       (opcode)
  );

  fr_sequencer #(.BUS_BYTES(BUS_BYTES), .LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (req_valid && req_ready),
    .opcode    (opcode),
    .addr4     (addr4),
    .dummy_eff (dummy_eff),
    .lanes_log (lanes_log),
    .addr      (req_addr),
    .len_m1    (req_len),
    .rsp_ready (rsp_ready),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .cs_n      (eng_cs_n),
    .sck       (eng_sck),
    .io_out    (eng_io_out),
    .io_oe     (eng_io_oe),
    .io_in     (flash_io_in)
  );

  fr_pin_mux u_mux (
    .own        (map_en || busy),
    .eng_cs_n   (eng_cs_n),
    .eng_sck    (eng_sck),
    .eng_io_out (eng_io_out),
    .eng_io_oe  (eng_io_oe),
    .reg_cs_n   (reg_cs_n),
    .reg_sck    (reg_sck),
    .reg_io_out (reg_io_out),
    .reg_io_oe  (reg_io_oe),
    .pin_cs_n   (flash_cs_n),
    .pin_sck    (flash_sck),
    .pin_io_out (flash_io_out),
    .pin_io_oe  (flash_io_oe)
  );
endmodule

// File: rtl/fr_checker.sv
module fr_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          map_en,
  input logic          busy,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic          reg_cs_n,
  input logic          reg_sck,
  input logic          flash_cs_n,
  input logic          flash_sck,
  input logic [3:0]    flash_io_oe
);
  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  // R8
  no_rerequest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  // R6
  cs_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !flash_cs_n && !flash_sck);
  // R6
  cs_before_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> flash_cs_n && !flash_sck);
  // R5
  lane0_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (flash_io_oe == 4'b0000 || flash_io_oe == 4'b0001));
  // R9
  fallback_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !map_en && !busy |-> flash_cs_n == reg_cs_n && flash_sck == reg_sck);
  // R9
  no_accept_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !map_en |-> !req_ready);
  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    map_en && !busy |-> flash_cs_n && !flash_sck);
endmodule

bind flash_map_reader fr_checker #(.DW(BUS_BYTES*8)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .map_en      (map_en),
  .busy        (busy),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_data    (rsp_data),
  .reg_cs_n    (reg_cs_n),
  .reg_sck     (reg_sck),
  .flash_cs_n  (flash_cs_n),
  .flash_sck   (flash_sck),
  .flash_io_oe (flash_io_oe)
);

// File: tb/flash_map_reader_test.sv
module flash_map_reader_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_en = 1'b1;
  logic [1:0]  cfg_width = '0;
  logic        cfg_fast = 1'b0;
  logic [2:0]  cfg_addr_len = 3'd3;
  logic        cfg_byte4_en = 1'b0;
  logic [3:0]  cfg_dummy = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_len = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_data;
  logic        reg_cs_n = 1'b1, reg_sck = 1'b0;
  logic [3:0]  reg_io_out = '0, reg_io_oe = '0;
  logic        flash_cs_n, flash_sck;
  logic [3:0]  flash_io_out, flash_io_oe;
  logic [3:0]  flash_io_in = '0;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  flash_map_reader uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural flash
  int          m_ab = 24, m_dm = 0, m_lanes = 1;
  int          ecnt = 0, dbit = 0;
  logic [7:0]  rx_op;
  logic [31:0] rx_addr;

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ {a[12:8], a[18:16]} ^ a[31:24] ^ 8'h5A;
  endfunction

  always @(negedge flash_cs_n) begin
    ecnt = 0; dbit = 0; rx_op = '0; rx_addr = '0;
  end

  always @(posedge flash_sck) if (!flash_cs_n) begin
    ecnt++;
    if (ecnt <= 8) rx_op = {rx_op[6:0], flash_io_out[0]};
    else if (ecnt <= 8 + m_ab) rx_addr = {rx_addr[30:0], flash_io_out[0]};
  end

  always @(negedge flash_sck) if (!flash_cs_n && ecnt >= 8 + m_ab + m_dm) begin
    logic [7:0] b;
    int pos;
    b = mem_byte(rx_addr + 32'(dbit / 8));
    pos = 7 - (dbit % 8);
    case (m_lanes)
      1: flash_io_in = {2'b00, b[pos], 1'b0};
      2: flash_io_in = {2'b00, b[pos], b[pos-1]};
      default: flash_io_in = b[pos -: 4];
    endcase
    dbit += m_lanes;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_op(input logic [1:0] w, input logic f,
                                        input logic a4);
    if (w[1]) return a4 ? 8'h6C : 8'h6B;
    if (w[0]) return a4 ? 8'h3C : 8'h3B;
    if (f)    return a4 ? 8'h0C : 8'h0B;
    return a4 ? 8'h13 : 8'h03;
  endfunction

  function automatic logic [31:0] exp_data(input logic [31:0] a, input logic [1:0] len);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i <= int'(len); i++) r[8*i +: 8] = mem_byte(a + 32'(i));
    return r;
  endfunction

  task automatic run_txn(input logic [31:0] a, input logic [1:0] len,
                         input logic [1:0] w, input logic f, input logic [2:0] al,
                         input logic b4, input logic [3:0] dm, input int stall,
                         input bit scramble);
    logic        a4;
    logic [31:0] fa, held;
    int          edges;
    a4      = b4 && (al == 3'd4);
    m_ab    = a4 ? 32 : 24;
    m_dm    = (f || w != 2'b00) ? int'(dm) : 0;
    m_lanes = w[1] ? 4 : (w[0] ? 2 : 1);
    fa      = a4 ? a : {8'h00, a[23:0]};
    @(negedge clk);
    req_addr = a; req_len = len; cfg_width = w; cfg_fast = f;
    cfg_addr_len = al; cfg_byte4_en = b4; cfg_dummy = dm; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) begin
      cfg_width = ~w; cfg_fast = ~f; cfg_byte4_en = ~b4; cfg_addr_len = 3'd4;
      cfg_dummy = ~dm; req_addr = ~a; req_len = ~len;
    end
    while (!rsp_valid) @(negedge clk);
    // R6: chip select already released while response waits
    chk(flash_cs_n == 1'b1, "R6 cs released", 64'(flash_cs_n), 64'd1);
    held = rsp_data;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      // R8: held under back-pressure
      chk(rsp_valid && rsp_data == held, "R8 rsp hold", 64'(rsp_data), 64'(held));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    edges = 8 + m_ab + m_dm + ((int'(len) + 1) * 8) / m_lanes;
    chk(rx_op == exp_op(w, f, a4), "R2 opcode", 64'(rx_op), 64'(exp_op(w, f, a4)));
    chk(rx_addr == fa, "R3 address", 64'(rx_addr), 64'(fa));
    chk(ecnt == edges, "R4 sck edge count", 64'(ecnt), 64'(edges));
    chk(held == exp_data(fa, len), scramble ? "R10 data after cfg change" : "R5 R7 data",
        64'(held), 64'(exp_data(fa, len)));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(flash_cs_n == 1'b1 && flash_sck == 1'b0, "R1 reset pins",
        {flash_cs_n, flash_sck}, 2'b10);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R1 reset handshake",
        {rsp_valid, req_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run_txn(32'h0012_3456, 2'd0, 2'b00, 1'b0, 3'd3, 1'b0, 4'd8, 0, 1'b0); // R4 plain: no dummy
    run_txn(32'hA1B2_C3D4, 2'd3, 2'b00, 1'b1, 3'd4, 1'b1, 4'd8, 2, 1'b0); // R3 4-byte fast
    run_txn(32'hA1B2_C3D4, 2'd1, 2'b01, 1'b0, 3'd4, 1'b0, 4'd4, 0, 1'b0); // R3 len 4 w/o enable
    run_txn(32'h0000_0FF0, 2'd3, 2'b10, 1'b0, 3'd3, 1'b1, 4'd6, 3, 1'b0); // R5 quad, R3 enable w/o len
    run_txn(32'h0055_0000, 2'd2, 2'b01, 1'b1, 3'd4, 1'b1, 4'd0, 1, 1'b0); // R4 dual zero dummy
    run_txn(32'h0034_5678, 2'd3, 2'b01, 1'b0, 3'd3, 1'b0, 4'd4, 0, 1'b1); // R10

    // R9: window off, pins follow register engine, no acceptance
    @(negedge clk);
    map_en = 1'b0; reg_cs_n = 1'b0; reg_sck = 1'b1; reg_io_out = 4'hA; reg_io_oe = 4'h5;
    req_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b0, "R9 no accept", 64'(req_ready), 64'd0);
    chk(flash_cs_n == 1'b0 && flash_sck == 1'b1 && flash_io_out == 4'hA && flash_io_oe == 4'h5,
        "R9 pins follow", {flash_cs_n, flash_sck, flash_io_out, flash_io_oe}, {2'b01, 8'hA5});
    chk(rsp_valid == 1'b0, "R9 no response", 64'(rsp_valid), 64'd0);
    req_valid = 1'b0; reg_cs_n = 1'b1; reg_sck = 1'b0;
    @(negedge clk);
    map_en = 1'b1;
    @(negedge clk);
    chk(flash_cs_n == 1'b1 && flash_sck == 1'b0, "R1 idle pins owned",
        {flash_cs_n, flash_sck}, 2'b10);

    // constrained random
    for (int t = 0; t < 40; t++) begin
      logic [31:0] ra;
      logic [2:0]  al;
      ra = $urandom;
      al = ($urandom % 2) ? 3'd4 : 3'd3;
      run_txn(ra, 2'($urandom), 2'($urandom), 1'($urandom), al, 1'($urandom),
              4'($urandom), int'($urandom % 3), 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule